// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Array Locks

This block is a 2-wire bus slave placed in front of a 256-byte memory, kept as a register array. A master reaches it with a device address whose upper four bits are a fixed code and whose low three bits come from strap inputs, so that up to eight copies can share one bus. A write transaction loads the internal word address. Any data bytes that follow are collected in a one-page pending buffer. A read transaction returns bytes from the word address and steps the address after each byte.

Each write that carries data ends, at the stop condition, with a self-timed busy period. The collected bytes are copied into the array only when that period ends. While the busy period runs, the slave answers no address. Two locks guard the array. A hardware pin discards all incoming write data while it is high. A one-time software lock, set through a second device-address code, discards all later writes to the lower half of the array. Only a reset clears the software lock.

SCL and SDA are sampled by the system clock through two-flop synchronizers. SDA is driven open-drain: `sdaOut` is held low and `sdaOe` pulls the line.

Top module: `twi_prom_slave`

## Requirements
- R1: After reset, `sdaOe` is low, every array byte reads 0xFF, and the software lock is clear.
- R2: The slave acknowledges a device byte {4'b1010, strap[2:0], rw}, where acknowledge means SDA is low during the ninth clock. A device byte with any other code or strap value gets no acknowledge, and the slave does not drive SDA.
- R3: A write transaction (device byte with rw=0, word address, data bytes sent MSB first, stop) stores the data from the word address upward. A random read (device write byte, word address, repeated start, device byte with rw=1) returns those bytes.
- R4: During a write, only the low 4 bits of the word address advance, and they wrap within the 16-byte page. Bytes past the 16th overwrite the page from its start, and the upper 4 bits never change.
- R5: A read steps the full 8-bit word address after each byte and wraps from 0xFF to 0x00. The master acknowledges each byte to continue and ends the read with a not-acknowledge.
- R6: While `wpPin` is high, data bytes are acknowledged but discarded, at any address.
- R7: A device byte {4'b0110, strap, 0} is acknowledged while the lock is clear, and the lock sets at the following stop. After that, writes to 0x00–0x7F are discarded, writes to 0x80–0xFF still take effect, and a further lock device byte gets no acknowledge.
- R8: A stop that ends a write with at least one data byte starts a busy period of `WriteCycles` clocks. During that period every device byte is left without acknowledge, and the data reach the array at its end. A write of only the word address starts no busy period.
- R9: A start condition that arrives before the stop drops any data bytes still pending, so they are never written and start no busy period.
- R10: `sdaOut` is always 0. `sdaOe` is high only during acknowledge bits the slave gives and during zero bits it transmits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Low device-address bits |
| wpPin | input | 1 | Whole-array write protect, active high |
| sclIn | input | 1 | Bus clock as seen on the wire |
| sdaIn | input | 1 | Bus data as seen on the wire |
| sdaOe | output | 1 | Pull SDA low when high |
| sdaOut | output | 1 | Open-drain data value, tied low |

## Verification
The hardest state to reach is the busy window. It opens only after a stop that ends a write with data, and it lasts a fixed number of clocks, so a probe of the address can arrive too late and miss it. The bench therefore sends a device byte at once after the stop of a one-byte write, expects no acknowledge, and then sends the same byte again after the window has closed. The repeated-start case is similar: data are left pending, and then a fresh start must drop them before any stop can commit them.

// File: rtl/twi_prom_pkg.sv
package twi_prom_pkg;
  localparam int ByteW = 8;
  localparam logic [3:0] MemCode  = 4'b1010;
  localparam logic [3:0] LockCode = 4'b0110;

  typedef struct packed {
    logic             startEvt;
    logic             stopEvt;
    logic             loadAddr;
    logic             wrByte;
    logic             rdAdvance;
    logic             setLock;
    logic [ByteW-1:0] data;
  } strobe_t;
endpackage

// File: rtl/twi_prom_ctrl.sv
module twi_prom_ctrl
  import twi_prom_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       strap,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             busy,
  input  logic             locked,
  input  logic [ByteW-1:0] rdData,
  output strobe_t          strb,
  output logic             sdaOe
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WA, ST_WA_ACK, ST_WD, ST_WD_ACK, ST_TX, ST_TX_ACK
  } state_t;

  state_t state;
  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic [ByteW-1:0] shiftReg;
  logic [3:0] bitCnt;
  logic readMode, lockMode, lockArm, masterAck;

  logic sclRise, sclFall, startDet, stopDet, memHit, lockHit;
  assign sclRise  = sclSync[1] & ~sclPrev;
  assign sclFall  = ~sclSync[1] & sclPrev;
  assign startDet = sclSync[1] & sclPrev & sdaPrev & ~sdaSync[1];
  assign stopDet  = sclSync[1] & sclPrev & ~sdaPrev & sdaSync[1];
  assign memHit   = shiftReg[7:1] == {MemCode, strap};
  assign lockHit  = shiftReg[7:1] == {LockCode, strap};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11; sclPrev <= 1'b1; sdaPrev <= 1'b1;
      state <= ST_IDLE; shiftReg <= '0; bitCnt <= '0; sdaOe <= 1'b0;
      readMode <= 1'b0; lockMode <= 1'b0; lockArm <= 1'b0; masterAck <= 1'b0;
      strb <= '0;
    end else begin
      strb <= '0;
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
      if (startDet) begin
        state <= ST_DEV; bitCnt <= '0; sdaOe <= 1'b0; lockArm <= 1'b0;
        strb.startEvt <= 1'b1;
      end else if (stopDet) begin
        state <= ST_IDLE; sdaOe <= 1'b0; lockArm <= 1'b0;
        strb.stopEvt <= 1'b1;
        strb.setLock <= lockArm;
      end else begin
        case (state)
          ST_DEV, ST_WA, ST_WD: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaSync[1]};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_DEV) begin
                if (!busy && memHit) begin
                  sdaOe <= 1'b1; state <= ST_DEV_ACK;
                  readMode <= shiftReg[0]; lockMode <= 1'b0;
                end else if (!busy && lockHit && !shiftReg[0] && !locked) begin
                  sdaOe <= 1'b1; state <= ST_DEV_ACK;
                  readMode <= 1'b0; lockMode <= 1'b1; lockArm <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaOe <= 1'b1;
                state <= (state == ST_WA) ? ST_WA_ACK : ST_WD_ACK;
                strb.data <= shiftReg;
                if (!lockMode) begin
                  strb.loadAddr <= (state == ST_WA);
                  strb.wrByte   <= (state == ST_WD);
                end
              end
            end
          end
          ST_DEV_ACK: if (sclFall) begin
            if (readMode) begin
              shiftReg <= rdData; sdaOe <= ~rdData[7]; bitCnt <= 4'd1;
              strb.rdAdvance <= 1'b1; state <= ST_TX;
            end else begin
              sdaOe <= 1'b0; bitCnt <= '0; state <= ST_WA;
            end
          end
          ST_WA_ACK, ST_WD_ACK: if (sclFall) begin
            sdaOe <= 1'b0; bitCnt <= '0; state <= ST_WD;
          end
          ST_TX: if (sclFall) begin
            if (bitCnt < 4'd8) begin
              shiftReg <= {shiftReg[6:0], 1'b0};
              sdaOe    <= ~shiftReg[6];
              bitCnt   <= bitCnt + 4'd1;
            end else begin
              sdaOe <= 1'b0; masterAck <= 1'b0; state <= ST_TX_ACK;
            end
          end
          ST_TX_ACK: begin
            if (sclRise) masterAck <= ~sdaSync[1];
            else if (sclFall) begin
              if (masterAck) begin
                shiftReg <= rdData; sdaOe <= ~rdData[7]; bitCnt <= 4'd1;
                strb.rdAdvance <= 1'b1; state <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: no address acknowledge while the write cycle runs
  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV_ACK) |-> !busy);

  // R10: the line is pulled only in acknowledge or transmit bits
  assert_drive_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state inside {ST_DEV_ACK, ST_WA_ACK, ST_WD_ACK, ST_TX}));
endmodule

// File: rtl/twi_prom_dpath.sv
module twi_prom_dpath
  import twi_prom_pkg::*;
#(
  parameter int AddrWidth   = 8,
  parameter int PageWidth   = 4,
  parameter int WriteCycles = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             wpPin,
  output logic             busy,
  output logic             locked,
  output logic [ByteW-1:0] rdData
);
  localparam int Depth    = 1 << AddrWidth;
  localparam int PageSize = 1 << PageWidth;
  localparam int CntWidth = $clog2(WriteCycles + 1);

  logic [ByteW-1:0]     mem [Depth];
  logic [ByteW-1:0]     pendData [PageSize];
  logic [PageSize-1:0]  pendValid;
  logic                 pendAny;
  logic [AddrWidth-1:0] wordAddr;
  logic [CntWidth-1:0]  busyCnt;
  logic                 blocked;

  assign rdData  = mem[wordAddr];
  // lower half is the top address bit clear
  assign blocked = wpPin | (locked & ~wordAddr[AddrWidth-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) mem[i] <= '1;
      for (int i = 0; i < PageSize; i++) pendData[i] <= '0;
      pendValid <= '0; pendAny <= 1'b0; wordAddr <= '0;
      busy <= 1'b0; busyCnt <= '0; locked <= 1'b0;
    end else begin
      if (strb.setLock) locked <= 1'b1;
      if (busy) begin
        if (busyCnt == '0) begin
          busy <= 1'b0;
          for (int i = 0; i < PageSize; i++)
            if (pendValid[i])
              mem[{wordAddr[AddrWidth-1:PageWidth], PageWidth'(i)}] <= pendData[i];
          pendValid <= '0;
        end else begin
          busyCnt <= busyCnt - 1'b1;
        end
      end else if (strb.startEvt) begin
        pendValid <= '0; pendAny <= 1'b0;
      end else if (strb.stopEvt) begin
        if (pendAny) begin
          busy <= 1'b1; busyCnt <= CntWidth'(WriteCycles - 1); pendAny <= 1'b0;
        end
      end else if (strb.loadAddr) begin
        wordAddr <= strb.data[AddrWidth-1:0];
      end else if (strb.wrByte) begin
        pendData[wordAddr[PageWidth-1:0]]  <= strb.data;
        pendValid[wordAddr[PageWidth-1:0]] <= ~blocked;
        pendAny <= 1'b1;
        wordAddr[PageWidth-1:0] <= wordAddr[PageWidth-1:0] + 1'b1;
      end else if (strb.rdAdvance) begin
        wordAddr <= wordAddr + 1'b1;
      end
    end
  end

  // R7: the software lock never clears without reset
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R6: a byte taken with the pin high adds no valid pending slot
  assert_wp_discard_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte && wpPin && !busy) |=> $countones(pendValid) <= $past($countones(pendValid)));

  // R4: page bits hold across data bytes
  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |=> wordAddr[AddrWidth-1:PageWidth] == $past(wordAddr[AddrWidth-1:PageWidth]));

  // R8: the write cycle opens only after a stop
  assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.stopEvt));
endmodule

// File: rtl/twi_prom_slave.sv
module twi_prom_slave
  import twi_prom_pkg::*;
#(
  parameter int AddrWidth   = 8,
  parameter int PageWidth   = 4,
  parameter int WriteCycles = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] strap,
  input  logic       wpPin,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic       sdaOut
);
  strobe_t strb;
  logic busy, locked;
  logic [ByteW-1:0] rdData;

  assign sdaOut = 1'b0;

  twi_prom_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .strap(strap), .sclIn(sclIn), .sdaIn(sdaIn),
    .busy(busy), .locked(locked), .rdData(rdData), .strb(strb), .sdaOe(sdaOe)
  );

  twi_prom_dpath #(
    .AddrWidth(AddrWidth), .PageWidth(PageWidth), .WriteCycles(WriteCycles)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wpPin(wpPin),
    .busy(busy), .locked(locked), .rdData(rdData)
  );
endmodule

// File: tb/twi_prom_slave_test.sv
module twi_prom_slave_test;
  localparam int WrCyc = 400;
  localparam int Q = 8;
  localparam logic [2:0] Strap = 3'b101;
  localparam logic [7:0] DevW  = {4'b1010, Strap, 1'b0};
  localparam logic [7:0] DevR  = {4'b1010, Strap, 1'b1};
  localparam logic [7:0] LockW = {4'b0110, Strap, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpPin = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, sdaOut, sdaLine;
  int nChecks = 0;
  int nFail = 0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  twi_prom_slave #(.WriteCycles(WrCyc)) uut (
    .clk(clk), .rstN(rstN), .strap(Strap), .wpPin(wpPin),
    .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe), .sdaOut(sdaOut)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic i2cStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic i2cStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask
  task automatic writeBit(input logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); b = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = ~b;
  endtask
  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin readBit(b); v[i] = b; end
    writeBit(~ackIt);
  endtask
  task automatic waitWrite(); repeat (WrCyc + 60) @(negedge clk); endtask

  task automatic writeBytes(input logic [7:0] addr, input int n, input string tag);
    logic a, allAck;
    i2cStart();
    sendByte(DevW, a); allAck = a;
    sendByte(addr, a); allAck &= a;
    for (int i = 0; i < n; i++) begin sendByte(wbuf[i], a); allAck &= a; end
    i2cStop();
    check({7'd0, allAck}, 8'd1, tag);
  endtask

  task automatic readBytes(input logic [7:0] addr, input int n, input string tag);
    logic a, allAck;
    logic [7:0] v;
    i2cStart();
    sendByte(DevW, a); allAck = a;
    sendByte(addr, a); allAck &= a;
    i2cStart();
    sendByte(DevR, a); allAck &= a;
    for (int i = 0; i < n; i++) begin recvByte(i < n - 1, v); rbuf[i] = v; end
    i2cStop();
    check({7'd0, allAck}, 8'd1, tag);
  endtask

  task automatic probe(input logic [7:0] dev, input logic exp, input string tag);
    logic a;
    i2cStart(); sendByte(dev, a); i2cStop();
    check({7'd0, a}, {7'd0, exp}, tag);
  endtask

  task automatic testReset();
    check({7'd0, sdaOe}, 8'd0, "R1 sdaOe idle");
    check({7'd0, sdaOut}, 8'd0, "R10 sdaOut low");
    readBytes(8'h00, 2, "R1 read acks");
    check(rbuf[0], 8'hFF, "R1 byte 00 erased");
    check(rbuf[1], 8'hFF, "R1 byte 01 erased");
  endtask

  task automatic testAddressMatch();
    probe(DevW, 1'b1, "R2 own address ack");
    probe({4'b1010, 3'b100, 1'b0}, 1'b0, "R2 other strap nack");
    probe({4'b1110, Strap, 1'b0}, 1'b0, "R2 other code nack");
    check({7'd0, sdaOe}, 8'd0, "R2 released after nack");
  endtask

  task automatic testByteWrite();
    wbuf[0] = 8'hA5;
    writeBytes(8'h45, 1, "R3 write acks");
    waitWrite();
    readBytes(8'h44, 2, "R3 read acks");
    check(rbuf[0], 8'hFF, "R3 neighbour untouched");
    check(rbuf[1], 8'hA5, "R3 stored byte");
  endtask

  task automatic testPageWrap();
    for (int i = 0; i < 18; i++) wbuf[i] = 8'h10 + 8'(i);
    writeBytes(8'h20, 18, "R4 write acks");
    waitWrite();
    readBytes(8'h20, 17, "R4 read acks");
    check(rbuf[0], 8'h20, "R4 wrapped byte at 20");
    check(rbuf[1], 8'h21, "R4 wrapped byte at 21");
    for (int k = 2; k < 16; k++) check(rbuf[k], 8'h10 + 8'(k), "R4 page body");
    check(rbuf[16], 8'hFF, "R4 next page untouched");
    check({7'd0, sdaOut}, 8'd0, "R10 sdaOut low");
  endtask

  task automatic testSeqRead();
    wbuf[0] = 8'h5E; wbuf[1] = 8'h5F;
    writeBytes(8'hFE, 2, "R5 setup acks");
    waitWrite();
    readBytes(8'hFE, 3, "R5 read acks");
    check(rbuf[0], 8'h5E, "R5 byte FE");
    check(rbuf[1], 8'h5F, "R5 byte FF");
    check(rbuf[2], 8'hFF, "R5 wrap to 00");
  endtask

  task automatic testWpPin();
    wpPin = 1'b1;
    wbuf[0] = 8'h33;
    writeBytes(8'h90, 1, "R6 data acked under pin");
    waitWrite();
    wpPin = 1'b0;
    readBytes(8'h90, 1, "R6 read acks");
    check(rbuf[0], 8'hFF, "R6 byte discarded");
  endtask

  task automatic testBusy();
    wbuf[0] = 8'h66;
    writeBytes(8'h60, 1, "R8 write acks");
    probe(DevW, 1'b0, "R8 nack while busy");
    waitWrite();
    probe(DevW, 1'b1, "R8 ack after busy");
    readBytes(8'h60, 1, "R8 read acks");
    check(rbuf[0], 8'h66, "R8 committed byte");
    writeBytes(8'h61, 0, "R8 address-only acks");
    probe(DevW, 1'b1, "R8 no busy without data");
  endtask

  task automatic testRestart();
    logic a;
    i2cStart();
    sendByte(DevW, a); sendByte(8'h70, a); sendByte(8'h77, a);
    i2cStart();
    sendByte(DevW, a);
    check({7'd0, a}, 8'd1, "R9 ack after repeated start");
    sendByte(8'h70, a);
    i2cStop();
    probe(DevW, 1'b1, "R9 no busy period");
    readBytes(8'h70, 1, "R9 read acks");
    check(rbuf[0], 8'hFF, "R9 pending byte dropped");
  endtask

  task automatic testLock();
    logic a, allAck;
    i2cStart();
    sendByte(LockW, a); allAck = a;
    sendByte(8'h00, a); allAck &= a;
    sendByte(8'h00, a); allAck &= a;
    i2cStop();
    check({7'd0, allAck}, 8'd1, "R7 lock access acked");
    probe(LockW, 1'b0, "R7 second lock nack");
    wbuf[0] = 8'hAB;
    writeBytes(8'h10, 1, "R7 low write acks");
    waitWrite();
    wbuf[0] = 8'hCD;
    writeBytes(8'h80, 1, "R7 high write acks");
    waitWrite();
    readBytes(8'h10, 1, "R7 read acks");
    check(rbuf[0], 8'hFF, "R7 low half locked");
    readBytes(8'h80, 1, "R7 read acks");
    check(rbuf[0], 8'hCD, "R7 upper half open");
    rstN = 1'b0; repeat (4) @(negedge clk); rstN = 1'b1; repeat (4) @(negedge clk);
    probe(LockW, 1'b1, "R1 lock clear after reset");
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testAddressMatch();
    testByteWrite();
    testPageWrap();
    testSeqRead();
    testWpPin();
    testBusy();
    testRestart();
    testLock();
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finishRun();
  end
endmodule